// File: doc/BRIEF.md
# Activate Rate Window Limiter

This block sits in front of the row-activate path of one DRAM rank and decides, cycle by cycle, whether an activate may be issued. It keeps the issue times of the most recent activates in a small circular store of age counters, together with the age and bank group of the very last activate. From these it forms one allow signal that is high only when both the activate-to-activate spacing rule and the rolling window rule are met for the bank group presented on the request lines.

Every time value is a programmable count of clock cycles, measured from the cycle in which an activate was accepted. The window may be set to any count from 1 up to the built-in depth, or switched off with a count of zero. Bank-group-aware spacing applies a longer gap between activates to the same group and the short gap otherwise. A request raised while allow is low is not recorded. It is reported on a reject flag one cycle later.

Top module: `act_window_gate`

## Requirements
- R1: With a nonzero window count N, an activate is refused while N accepted activates have issue times fewer than `cfgWindow` cycles before the current cycle. It is allowed again once the oldest of the last N is `cfgWindow` or more cycles old.
- R2: A window count of 0 disables the window check entirely, so only the spacing rules govern allow.
- R3: Between any two accepted activates at least `cfgGapShort` cycles must pass. Allow is low while the last activate is fewer than that many cycles old.
- R4: When bank groups are in use (`cfgGroupEn` high and `cfgGapLong` nonzero), an activate whose `actGroup` equals the group of the last accepted activate needs at least `cfgGapLong` cycles since that activate. A different group needs only `cfgGapShort`.
- R5: With `cfgGroupEn` low, or `cfgGapLong` zero, the short gap applies even when the group repeats.
- R6: Window counts smaller than the built-in depth (for example 1 or 2) limit the window to exactly that many activates.
- R7: A request with `actAllow` low raises `actReject` for exactly the next cycle and is not recorded: it changes neither the spacing nor the window history. An accepted request leaves `actReject` low.
- R8: After reset no history exists. `actAllow` is high for any group and `actReject` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset, clears all history |
| cfgLimit | input | LIM_W | Activates allowed per window, 0 disables the window |
| cfgWindow | input | CNT_W | Window length in cycles |
| cfgGapShort | input | CNT_W | Minimum cycles between any two activates |
| cfgGapLong | input | CNT_W | Minimum cycles between activates to the same bank group, 0 disables groups |
| cfgGroupEn | input | 1 | Bank groups present |
| actReq | input | 1 | Activate strobe, accepted when actAllow is high |
| actGroup | input | GROUP_W | Bank group of the requested activate |
| actAllow | output | 1 | Activate permitted this cycle for actGroup |
| actReject | output | 1 | Previous cycle's strobe was refused |

## Verification
The assertions assume the configuration inputs are static between resets and that `cfgLimit` never exceeds the built-in depth. Under those assumptions the circular pointer stays within the active window count and an accepted activate always meets the recorded ages. The bench changes configuration only while reset is held, with every window count within the depth. It sweeps window counts, window lengths, short and long gaps and group enable, and drives a fixed strobe and group pattern that often requests while allow is low. That way the reject path and the unchanged history after a refusal are exercised in every configuration.

// File: rtl/act_window_pkg.sv
package act_window_pkg;
  // Strobes passed from control to the history datapath
  typedef struct packed {
    logic rec;     // accepted activate: restart last-activate age, latch group
    logic slotWr;  // accepted activate that also enters the window store
  } actStrobes_t;
endpackage

// File: rtl/act_window_dp.sv
module act_window_dp
  import act_window_pkg::*;
#(
  parameter int MAX_ACT = 4,
  parameter int CNT_W   = 8,
  parameter int GROUP_W = 2,
  parameter int PTR_W   = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  actStrobes_t        strb,
  input  logic [PTR_W-1:0]   slotSel,
  input  logic [GROUP_W-1:0] grpIn,
  output logic [CNT_W-1:0]   oldAge,
  output logic               oldValid,
  output logic [CNT_W-1:0]   lastAge,
  output logic [GROUP_W-1:0] lastGroup,
  output logic               lastValid
);
  localparam logic [CNT_W-1:0] AGE_MAX = '1;
  localparam logic [CNT_W-1:0] AGE_ONE = CNT_W'(1);

  logic [CNT_W-1:0] slotAge   [MAX_ACT];
  logic [MAX_ACT-1:0] slotValid;

  for (genvar i = 0; i < MAX_ACT; i++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotAge[i]   <= '0;
        slotValid[i] <= 1'b0;
      end else if (strb.slotWr && slotSel == PTR_W'(i)) begin
        slotAge[i]   <= AGE_ONE;
        slotValid[i] <= 1'b1;
      end else if (slotAge[i] != AGE_MAX) begin
        slotAge[i]   <= slotAge[i] + AGE_ONE;
      end
    end
  end

  always_comb begin
    oldAge   = '0;
    oldValid = 1'b0;
    for (int k = 0; k < MAX_ACT; k++) begin
      if (slotSel == PTR_W'(k)) begin
        oldAge   = slotAge[k];
        oldValid = slotValid[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastAge   <= '0;
      lastGroup <= '0;
      lastValid <= 1'b0;
    end else if (strb.rec) begin
      lastAge   <= AGE_ONE;
      lastGroup <= grpIn;
      lastValid <= 1'b1;
    end else if (lastAge != AGE_MAX) begin
      lastAge   <= lastAge + AGE_ONE;
    end
  end

  AST_AGE_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    strb.rec |=> (lastAge == AGE_ONE) && lastValid); // R3
  AST_AGE_MONO: assert property (@(posedge clk) disable iff (!rstN)
    (lastValid && !strb.rec) |=> (lastAge >= $past(lastAge)) && lastValid); // R3
  AST_GROUP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rec |=> $stable(lastGroup)); // R7
endmodule

// File: rtl/act_window_ctrl.sv
module act_window_ctrl
  import act_window_pkg::*;
#(
  parameter int MAX_ACT = 4,
  parameter int CNT_W   = 8,
  parameter int GROUP_W = 2,
  parameter int PTR_W   = 2,
  parameter int LIM_W   = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [LIM_W-1:0]   cfgLimit,
  input  logic [CNT_W-1:0]   cfgWindow,
  input  logic [CNT_W-1:0]   cfgGapShort,
  input  logic [CNT_W-1:0]   cfgGapLong,
  input  logic               cfgGroupEn,
  input  logic               actReq,
  input  logic [GROUP_W-1:0] actGroup,
  input  logic [CNT_W-1:0]   oldAge,
  input  logic               oldValid,
  input  logic [CNT_W-1:0]   lastAge,
  input  logic [GROUP_W-1:0] lastGroup,
  input  logic               lastValid,
  output actStrobes_t        strb,
  output logic [PTR_W-1:0]   slotSel,
  output logic               actAllow,
  output logic               actReject
);
  localparam logic [LIM_W-1:0] LIM_MAX = LIM_W'(MAX_ACT);

  logic [LIM_W-1:0] effLimit;
  logic [PTR_W-1:0] lastSlot;
  logic             groupsUsed;
  logic [CNT_W-1:0] needGap;
  logic             gapOk;
  logic             winOk;
  logic             winOn;

  assign effLimit   = (cfgLimit > LIM_MAX) ? LIM_MAX : cfgLimit;
  assign winOn      = (effLimit != '0);
  assign lastSlot   = PTR_W'(effLimit - LIM_W'(1));
  assign groupsUsed = cfgGroupEn && (cfgGapLong != '0);
  assign needGap    = (groupsUsed && actGroup == lastGroup) ? cfgGapLong : cfgGapShort;
  assign gapOk      = !lastValid || (lastAge >= needGap);
  assign winOk      = !winOn || !oldValid || (oldAge >= cfgWindow);
  assign actAllow   = gapOk && winOk;

  always_comb begin
    strb.rec    = actReq && actAllow;
    strb.slotWr = actReq && actAllow && winOn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotSel   <= '0;
      actReject <= 1'b0;
    end else begin
      actReject <= actReq && !actAllow;
      if (strb.slotWr) slotSel <= (slotSel == lastSlot) ? '0 : slotSel + PTR_W'(1);
    end
  end

  AST_NO_EARLY_ACT: assert property (@(posedge clk) disable iff (!rstN)
    strb.rec |-> (!lastValid || lastAge >= cfgGapShort)); // R3
  AST_WIN_RESPECT: assert property (@(posedge clk) disable iff (!rstN)
    strb.slotWr |-> (!oldValid || oldAge >= cfgWindow)); // R1
  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    winOn |-> (PTR_W'(slotSel) <= lastSlot)); // R6
  AST_REJECT_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (actReq && !actAllow) |=> actReject); // R7
  AST_ACCEPT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!actReq || actAllow) |=> !actReject); // R7
endmodule

// File: rtl/act_window_gate.sv
module act_window_gate
  import act_window_pkg::*;
#(
  parameter int MAX_ACT = 4,
  parameter int CNT_W   = 8,
  parameter int GROUP_W = 2,
  parameter int LIM_W   = $clog2(MAX_ACT + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [LIM_W-1:0]   cfgLimit,
  input  logic [CNT_W-1:0]   cfgWindow,
  input  logic [CNT_W-1:0]   cfgGapShort,
  input  logic [CNT_W-1:0]   cfgGapLong,
  input  logic               cfgGroupEn,
  input  logic               actReq,
  input  logic [GROUP_W-1:0] actGroup,
  output logic               actAllow,
  output logic               actReject
);
  localparam int PTR_W = (MAX_ACT > 1) ? $clog2(MAX_ACT) : 1;

  actStrobes_t        strb;
  logic [PTR_W-1:0]   slotSel;
  logic [CNT_W-1:0]   oldAge;
  logic               oldValid;
  logic [CNT_W-1:0]   lastAge;
  logic [GROUP_W-1:0] lastGroup;
  logic               lastValid;

  act_window_ctrl #(
    .MAX_ACT(MAX_ACT), .CNT_W(CNT_W), .GROUP_W(GROUP_W), .PTR_W(PTR_W), .LIM_W(LIM_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN),
    .cfgLimit(cfgLimit), .cfgWindow(cfgWindow), .cfgGapShort(cfgGapShort),
    .cfgGapLong(cfgGapLong), .cfgGroupEn(cfgGroupEn),
    .actReq(actReq), .actGroup(actGroup),
    .oldAge(oldAge), .oldValid(oldValid), .lastAge(lastAge),
    .lastGroup(lastGroup), .lastValid(lastValid),
    .strb(strb), .slotSel(slotSel), .actAllow(actAllow), .actReject(actReject)
  );

  act_window_dp #(
    .MAX_ACT(MAX_ACT), .CNT_W(CNT_W), .GROUP_W(GROUP_W), .PTR_W(PTR_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .slotSel(slotSel), .grpIn(actGroup),
    .oldAge(oldAge), .oldValid(oldValid), .lastAge(lastAge),
    .lastGroup(lastGroup), .lastValid(lastValid)
  );
endmodule

// File: tb/sim_act_window_gate.sv
module sim_act_window_gate;
  localparam int MAX_ACT = 4;
  localparam int CNT_W   = 6;
  localparam int GROUP_W = 2;
  localparam int LIM_W   = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [LIM_W-1:0]   cfgLimit = '0;
  logic [CNT_W-1:0]   cfgWindow = '0;
  logic [CNT_W-1:0]   cfgGapShort = '0;
  logic [CNT_W-1:0]   cfgGapLong = '0;
  logic               cfgGroupEn = 1'b0;
  logic               actReq = 1'b0;
  logic [GROUP_W-1:0] actGroup = '0;
  logic actAllow, actReject;

  int testCnt = 0;
  int failCnt = 0;

  always #5 clk = ~clk;

  act_window_gate #(.MAX_ACT(MAX_ACT), .CNT_W(CNT_W), .GROUP_W(GROUP_W), .LIM_W(LIM_W)) u0 (
    .clk(clk), .rstN(rstN), .cfgLimit(cfgLimit), .cfgWindow(cfgWindow),
    .cfgGapShort(cfgGapShort), .cfgGapLong(cfgGapLong), .cfgGroupEn(cfgGroupEn),
    .actReq(actReq), .actGroup(actGroup), .actAllow(actAllow), .actReject(actReject)
  );

  // reference history
  int hist [256];
  int histN;
  int lastTime;
  int lastGrp;

  task automatic check(input string req, input logic act, input logic exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic doReset();
    actReq = 1'b0;
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    histN = 0;
    lastTime = 0;
    lastGrp = 0;
  endtask

  task automatic runConfig(input int lim, input int win, input int gs, input int gl,
                           input bit ge, input int seed);
    bit prevRej;
    cfgLimit = LIM_W'(lim); cfgWindow = CNT_W'(win);
    cfgGapShort = CNT_W'(gs); cfgGapLong = CNT_W'(gl); cfgGroupEn = ge;
    doReset();
    prevRej = 1'b0;
    for (int c = 0; c < 60; c++) begin
      bit a, gapOk, winOk, expAllow, used, same;
      int g, need;
      string tag;
      a = (((c * 3) + seed) % 5) != 0;
      g = ((c / 2) + seed) % 4;
      actReq = a;
      actGroup = GROUP_W'(g);
      #1;
      used = ge && (gl != 0);
      same = (histN > 0) && (g == lastGrp);
      need = (used && same) ? gl : gs;
      gapOk = (histN == 0) || (c - lastTime >= need);
      winOk = (lim == 0) || (histN < lim) || (c - hist[histN - lim] >= win);
      expAllow = gapOk && winOk;
      if (!winOk) tag = (lim < MAX_ACT) ? "R6" : "R1";
      else if (!gapOk) tag = (used && same) ? "R4" : "R3";
      else if (lim == 0) tag = "R2";
      else if (same && !used) tag = "R5";
      else tag = "R3";
      check(tag, actAllow, expAllow);
      check("R7", actReject, prevRej);
      prevRej = a && !expAllow;
      if (a && expAllow) begin
        hist[histN] = c;
        histN++;
        lastTime = c;
        lastGrp = g;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    int idx;
    @(negedge clk);
    doReset();
    #1;
    // R8: empty history after reset
    for (int g = 0; g < 4; g++) begin
      actGroup = GROUP_W'(g);
      #1;
      check("R8", actAllow, 1'b1);
    end
    check("R8", actReject, 1'b0);
    idx = 0;
    for (int li = 0; li < 4; li++) begin
      for (int wi = 0; wi < 2; wi++) begin
        for (int si = 0; si < 2; si++) begin
          for (int gi = 0; gi < 2; gi++) begin
            for (int ei = 0; ei < 2; ei++) begin
              int lim;
              lim = (li == 3) ? 4 : li;
              runConfig(lim, (wi == 0) ? 5 : 9, (si == 0) ? 1 : 3,
                        (gi == 0) ? 0 : 6, ei[0], idx % 5);
              idx++;
            end
          end
        end
      end
    end
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule